// File: doc/BRIEF.md
# Issue-Stepped Result Pipeline

This block is an arithmetic pipeline that moves forward only when an operation is issued. It does not move on every clock. Each issue brings two source operands, an operation select and a destination tag. The tag does not belong to the operation being started. It labels the result that leaves the last stage on this same advance. A program therefore sees the pipeline latency directly: it supplies the tag for a result several issues after it started the operation that produced it.

The pipeline has two modes. The single-length mode has a fixed number of stages and does either an add or a multiply. The double-length mode is multiply-only and has fewer stages. Each stage in that mode lasts two clocks, so the block reports busy in the second clock and can retire at most one result every two cycles. The arithmetic is modelled as integer add and multiply, truncated to the data width.

Each stage has a valid bit, so empty slots never produce a write. A flush empties the whole pipeline in one cycle. A mode change is accepted only when nothing is in flight.

Top module: `issue_step_pipe`

## Requirements
- R1: After reset, wb_valid, busy and mode_err are 0, and cur_mode is 0, which selects single-length mode.
- R2: The stages advance only on an accepted issue, where accepted means iss_valid=1, busy=0 and flush=0. With no accepted issue, results in flight are held and no writeback occurs.
- R3: On an accepted issue that pushes a valid result out of the last stage, the next cycle shows wb_valid=1, wb_data equal to that result, and wb_tag equal to the iss_dest of the pushing issue.
- R4: In single-length mode (cur_mode=0), the result of issue k leaves on issue k+3.
- R5: In double-length mode (cur_mode=1), the result of issue k leaves on issue k+2.
- R6: In double-length mode, busy is 1 in the cycle after each accepted issue. An issue attempted while busy=1 is ignored: nothing advances and no writeback occurs. In single-length mode, busy stays 0.
- R7: Slots that were emptied by reset or flush produce no writeback. In single-length mode, the first three issues after reset or flush give wb_valid=0.
- R8: In single-length mode, iss_op=0 gives (a+b) mod 2^DATA_W and iss_op=1 gives (a*b) mod 2^DATA_W. In double-length mode, the result is always the product, whatever iss_op is.
- R9: A mode write (mode_wr=1) sets cur_mode to mode_sel when no stage is valid and no issue is accepted in the same cycle. Otherwise the write is rejected: cur_mode is unchanged and mode_err is 1 for exactly the next cycle. A mode write in the same cycle as a flush succeeds.
- R10: Flush clears every valid bit and the busy flag in one cycle, and it takes priority over an issue in the same cycle. In the cycle after a flush, wb_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 1 | 0 = add, 1 = multiply (single-length mode only) |
| iss_a | input | DATA_W | First operand |
| iss_b | input | DATA_W | Second operand |
| iss_dest | input | TAG_W | Tag for the result leaving on this issue |
| flush | input | 1 | Empty the pipeline |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 1 | Requested mode: 0 = single-length, 1 = double-length |
| busy | output | 1 | Second cycle of a double-length stage; issues are ignored |
| cur_mode | output | 1 | Current mode |
| mode_err | output | 1 | One-cycle pulse for a rejected mode write |
| wb_valid | output | 1 | Writeback strobe |
| wb_tag | output | TAG_W | Writeback destination tag |
| wb_data | output | DATA_W | Writeback result |

## Verification
The bench builds the block with DATA_W=4 and TAG_W=3. This makes the operand space small enough to sweep every pair of 4-bit operands through both operations in single-length mode, and every pair again in double-length mode. Every wrap-around case of the truncated sum and product is therefore compared against the bench's own arithmetic. The 3-bit tag wraps many times during the sweeps, which tests the rule that the exiting result takes the later issue's tag. Short runs then cover freezing, flush priority and mode writes that are rejected and accepted.

// File: rtl/isp_pkg.sv
package isp_pkg;
   typedef enum logic {
      MODE_SGL = 1'b0,
      MODE_DBL = 1'b1
   } isp_mode_e;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_MUL = 1'b1
   } isp_op_e;
endpackage

// File: rtl/isp_alu.sv
module isp_alu #(
   parameter int  DATA_W   = 16,
   parameter bit  FAST_MUL = 1'b1
) (
   input  logic              op_mul,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] prod;
   logic [DATA_W-1:0] sum;

   assign sum = opa + opb;

   generate
      if (FAST_MUL) begin : g_mul_op
         assign prod = opa * opb;
      end else begin : g_mul_shift
         logic [DATA_W-1:0] pp [DATA_W];
         for (genvar k = 0; k < DATA_W; k++) begin : g_pp
            assign pp[k] = opb[k] ? (opa << k) : '0;
         end
         always_comb begin
            prod = '0;
            for (int j = 0; j < DATA_W; j++) begin
               prod = prod + pp[j];
            end
         end
      end
   endgenerate

   assign res = op_mul ? prod : sum;
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
   import isp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic iss_valid,
   input  logic flush,
   input  logic mode_wr,
   input  logic mode_sel,
   input  logic any_valid,
   output logic accept,
   output logic busy,
   output logic cur_mode,
   output logic mode_err
);
   isp_mode_e mode_q;
   logic      pending;

   assign accept   = iss_valid && !busy && !flush;
   assign pending  = (any_valid && !flush) || accept;
   assign cur_mode = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (flush) begin
         busy <= 1'b0;
      end else begin
         busy <= accept && (mode_q == MODE_DBL);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_SGL;
         mode_err <= 1'b0;
      end else begin
         mode_err <= 1'b0;
         if (mode_wr) begin
            if (pending) begin
               mode_err <= 1'b1;
            end else begin
               mode_q <= isp_mode_e'(mode_sel);
            end
         end
      end
   end
endmodule

// File: rtl/isp_stages.sv
module isp_stages #(
   parameter int DATA_W   = 16,
   parameter int SGL_DEPTH = 3,
   parameter int DBL_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              flush,
   input  logic              sel_dbl,
   input  logic [DATA_W-1:0] new_data,
   output logic              exit_valid,
   output logic [DATA_W-1:0] exit_data,
   output logic              any_valid
);
   logic [SGL_DEPTH-1:0] vld;
   logic [SGL_DEPTH-1:0] vld_nxt;
   logic [DATA_W-1:0]    dat [SGL_DEPTH];

   assign vld_nxt[0] = 1'b1;

   generate
      for (genvar i = 1; i < SGL_DEPTH; i++) begin : g_vnext
         if (i < DBL_DEPTH) begin : g_shared
            assign vld_nxt[i] = vld[i-1];
         end else begin : g_sgl_only
            assign vld_nxt[i] = vld[i-1] && !sel_dbl;
         end
      end

      for (genvar i = 0; i < SGL_DEPTH; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (accept) begin
               if (i == 0) begin
                  dat[i] <= new_data;
               end else begin
                  dat[i] <= dat[(i == 0) ? 0 : i-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (flush) begin
         vld <= '0;
      end else if (accept) begin
         vld <= vld_nxt;
      end
   end

   assign exit_valid = sel_dbl ? vld[DBL_DEPTH-1] : vld[SGL_DEPTH-1];
   assign exit_data  = sel_dbl ? dat[DBL_DEPTH-1] : dat[SGL_DEPTH-1];
   assign any_valid  = |vld;
endmodule

// File: rtl/issue_step_pipe.sv
module issue_step_pipe
   import isp_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int TAG_W     = 5,
   parameter int SGL_DEPTH = 3,
   parameter int DBL_DEPTH = 2,
   parameter bit FAST_MUL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic              iss_op,
   input  logic [DATA_W-1:0] iss_a,
   input  logic [DATA_W-1:0] iss_b,
   input  logic [TAG_W-1:0]  iss_dest,
   input  logic              flush,
   input  logic              mode_wr,
   input  logic              mode_sel,
   output logic              busy,
   output logic              cur_mode,
   output logic              mode_err,
   output logic              wb_valid,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [DATA_W-1:0] wb_data
);
   generate
      if (DATA_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("issue_step_pipe: widths must be positive");
      end
      if (SGL_DEPTH < 2 || DBL_DEPTH < 1 || DBL_DEPTH > SGL_DEPTH) begin : g_bad_depth
         $error("issue_step_pipe: need 1 <= DBL_DEPTH <= SGL_DEPTH, SGL_DEPTH >= 2");
      end
   endgenerate

   logic              accept;
   logic              any_valid;
   logic              exit_valid;
   logic [DATA_W-1:0] exit_data;
   logic [DATA_W-1:0] alu_res;
   logic              op_mul;

   isp_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .flush     (flush),
      .mode_wr   (mode_wr),
      .mode_sel  (mode_sel),
      .any_valid (any_valid),
      .accept    (accept),
      .busy      (busy),
      .cur_mode  (cur_mode),
      .mode_err  (mode_err)
   );

   assign op_mul = (cur_mode == MODE_DBL) || (iss_op == OP_MUL);

   isp_alu #(
      .DATA_W   (DATA_W),
      .FAST_MUL (FAST_MUL)
   ) u_alu (
      .op_mul (op_mul),
      .opa    (iss_a),
      .opb    (iss_b),
      .res    (alu_res)
   );

   isp_stages #(
      .DATA_W    (DATA_W),
      .SGL_DEPTH (SGL_DEPTH),
      .DBL_DEPTH (DBL_DEPTH)
   ) u_stages (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .flush      (flush),
      .sel_dbl    (cur_mode),
      .new_data   (alu_res),
      .exit_valid (exit_valid),
      .exit_data  (exit_data),
      .any_valid  (any_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_tag   <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= accept && exit_valid;
         if (accept) begin
            wb_tag  <= iss_dest;
            wb_data <= exit_data;
         end
      end
   end
endmodule

// File: rtl/isp_checks.sv
module isp_checks (
   input logic clk,
   input logic rst_n,
   input logic iss_valid,
   input logic flush,
   input logic busy,
   input logic cur_mode,
   input logic mode_err,
   input logic wb_valid
);
   p_wb_needs_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(iss_valid && !busy && !flush));

   p_busy_after_dbl_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode && iss_valid && !busy && !flush) |=> busy);

   p_busy_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($past(iss_valid && !busy && !flush) && cur_mode));

   p_sgl_never_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_mode |-> !busy);

   p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush) |-> (!wb_valid && !busy));

   p_reject_keeps_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> $stable(cur_mode));
endmodule

bind issue_step_pipe isp_checks u_isp_checks (.*);

// File: tb/tb_issue_step_pipe.sv
module tb_issue_step_pipe;
   localparam int W  = 4;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic          iss_op = 1'b0;
   logic [W-1:0]  iss_a = '0;
   logic [W-1:0]  iss_b = '0;
   logic [TW-1:0] iss_dest = '0;
   logic          flush = 1'b0;
   logic          mode_wr = 1'b0;
   logic          mode_sel = 1'b0;
   logic          busy, cur_mode, mode_err, wb_valid;
   logic [TW-1:0] wb_tag;
   logic [W-1:0]  wb_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   int m_v [3];
   int m_d [3];
   int depth = 3;
   int dcount = 0;

   always #4 clk = ~clk;

   issue_step_pipe #(.DATA_W(W), .TAG_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_a(iss_a), .iss_b(iss_b), .iss_dest(iss_dest), .flush(flush),
      .mode_wr(mode_wr), .mode_sel(mode_sel), .busy(busy), .cur_mode(cur_mode),
      .mode_err(mode_err), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 3; i++) m_v[i] = 0;
   endtask

   task automatic do_issue(input int a, input int b, input int op, input string req);
      int ev, ed, et, nv;
      iss_valid = 1'b1;
      iss_a     = W'(a);
      iss_b     = W'(b);
      iss_op    = op[0];
      iss_dest  = TW'(dcount);
      ev = m_v[depth-1];
      ed = m_d[depth-1];
      et = dcount % (1 << TW);
      if (depth == 2 || op == 1) nv = (a * b) % (1 << W);
      else nv = (a + b) % (1 << W);
      for (int i = 2; i > 0; i--) begin
         m_v[i] = m_v[i-1];
         m_d[i] = m_d[i-1];
      end
      m_v[0] = 1;
      m_d[0] = nv;
      @(posedge clk);
      @(negedge clk);
      iss_valid = 1'b0;
      dcount++;
      if (ev != 0)
         chk(wb_valid && wb_data == W'(ed) && wb_tag == TW'(et), req, "writeback data/tag",
             wb_valid ? {wb_tag, wb_data} : -1, {et[TW-1:0], ed[W-1:0]});
      else
         chk(!wb_valid, req, "no writeback expected", wb_valid, 0);
   endtask

   task automatic stalled_try(input string req);
      iss_valid = 1'b1;
      iss_a = 4'hF; iss_b = 4'hF; iss_dest = '1;
      @(posedge clk);
      @(negedge clk);
      iss_valid = 1'b0;
      chk(!wb_valid && !busy, req, "issue while busy must be ignored", wb_valid, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         finish_run();
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!wb_valid && !busy && !mode_err && !cur_mode, "R1", "reset outputs",
          {wb_valid, busy, mode_err, cur_mode}, 0);

      // R4 R8 R3 R7: full single-length sweep, add then multiply
      for (int op = 0; op < 2; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               do_issue(a, b, op, "R4/R8/R3/R7");

      // R2: idle cycles freeze the pipeline
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!wb_valid, "R2", "no writeback while idle", wb_valid, 0);
      end
      do_issue(3, 4, 0, "R2");
      do_issue(5, 6, 1, "R2");
      do_issue(7, 9, 0, "R2");

      // R9: mode write with work pending is rejected
      mode_wr = 1'b1; mode_sel = 1'b1;
      @(posedge clk); @(negedge clk);
      mode_wr = 1'b0;
      chk(mode_err && !cur_mode, "R9", "pending mode write rejected",
          {mode_err, cur_mode}, 2);
      @(negedge clk);
      chk(!mode_err, "R9", "mode_err one cycle", mode_err, 0);

      // R9: mode write alongside an accepted issue on empty... reject case via issue
      // R10: flush beats a simultaneous issue
      flush = 1'b1; iss_valid = 1'b1; iss_a = 4'h2; iss_b = 4'h3;
      @(posedge clk); @(negedge clk);
      flush = 1'b0; iss_valid = 1'b0;
      chk(!wb_valid && !busy, "R10", "quiet after flush", wb_valid, 0);
      model_clear();
      do_issue(1, 1, 0, "R10/R7");
      do_issue(2, 2, 0, "R10/R7");
      do_issue(3, 3, 0, "R10/R7");
      do_issue(4, 4, 1, "R10/R4");

      // R9: mode write together with a flush is accepted
      flush = 1'b1; mode_wr = 1'b1; mode_sel = 1'b1;
      @(posedge clk); @(negedge clk);
      flush = 1'b0; mode_wr = 1'b0;
      chk(cur_mode && !mode_err, "R9", "mode write during flush accepted",
          {cur_mode, mode_err}, 2);
      model_clear();
      depth = 2;

      // R5 R6 R8: double-length sweep with stalled attempts
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) begin
            do_issue(a, b, (a + b) % 2, "R5/R8");
            chk(busy, "R6", "busy after double-length issue", busy, 1);
            stalled_try("R6");
         end

      // R9: mode write in the same cycle as an accepted issue is rejected
      flush = 1'b1;
      @(posedge clk); @(negedge clk);
      flush = 1'b0;
      model_clear();
      mode_wr = 1'b1; mode_sel = 1'b0; iss_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      mode_wr = 1'b0; iss_valid = 1'b0;
      chk(mode_err && cur_mode, "R9", "write with issue rejected", {mode_err, cur_mode}, 3);

      // R9: empty pipeline accepts a return to single-length mode
      flush = 1'b1;
      @(posedge clk); @(negedge clk);
      flush = 1'b0;
      mode_wr = 1'b1; mode_sel = 1'b0;
      @(posedge clk); @(negedge clk);
      mode_wr = 1'b0;
      chk(!cur_mode && !mode_err, "R9", "mode write on empty pipe", {cur_mode, mode_err}, 0);
      model_clear();
      depth = 3;
      do_issue(9, 9, 1, "R7");
      chk(!busy, "R6", "no busy in single-length mode", busy, 0);
      do_issue(8, 9, 0, "R7");
      do_issue(7, 9, 1, "R7");
      do_issue(0, 0, 0, "R4");

      finish_run();
   end
endmodule